// File: doc/BRIEF.md
# Encoded Interrupt Level Decoder

This block sits between a four-bit encoded external interrupt level and an interrupt controller that has one request input per source. A level of zero means that nothing is requested. Any other level picks exactly one of fifteen sources. The source index is the level XORed with all-ones. The highest level, 15, therefore lands on index 0, and the lowest level, 1, lands on index 14.

The decoder samples the level on each cycle where the valid strobe is high. It then drives the request line of the chosen source high and clears every other request line in that same update. Between updates it holds its outputs.

A second vector forces the enable of every source that the decoder has selected. A source that is selected for the first time has its enable forced on. In the default sticky variant, that force stays on until reset. This matches an enable count that the decoder raises once and never lowers. A follow variant can be chosen by parameter, in which the force simply mirrors the request.

Top module: `irl_level_decoder`

## Requirements
- R1: While reset is asserted and after it is released, before any update, all request lines and all enable forces are low.
- R2: One clock edge after an update with a nonzero level L, exactly the request at index L XOR 15 is high. Level 15 selects index 0 and level 1 selects index 14.
- R3: One clock edge after an update with level 0, all request lines are low.
- R4: On edges where the valid strobe is low, the request lines and the enable forces keep their values, whatever the level input carries.
- R5: A request left high by an earlier update is cleared in the same update that selects a different source or level 0.
- R6: In the update that selects a source, that source's enable force is high, so every high request line has its enable force high.
- R7: With the sticky variant (default), an enable force, once set, stays high until reset, including after its source is deselected.
- R8: At no time is more than one request line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_valid | input | 1 | High on cycles where lvl_code is to be applied |
| lvl_code | input | 4 | Encoded level: 0 means none, 15 is the highest |
| src_req | output | 15 | Per-source request lines, bit i for source index i |
| src_en_force | output | 15 | Per-source enable force |

## Verification
The hardest behaviour to expose is the difference between request and enable force. After a run of several levels, the enable-force vector must be the union of every source selected since reset, while only one request is live. The stimulus first sweeps all fifteen levels. It then goes back to earlier levels and to level 0, so a sticky force that was cleared wrongly, or a stale request that was left set, shows up at the ports. Idle cycles carrying changing level codes with the strobe low check that nothing moves between updates.

// File: rtl/irl_level_pkg.sv
package irl_level_pkg;
   typedef enum logic [0:0] {
      ENF_STICKY = 1'b0,
      ENF_FOLLOW = 1'b1
   } enf_mode_e;
endpackage

// File: rtl/irl_sel_decode.sv
module irl_sel_decode #(
   parameter int LVL_W = 4,
   parameter int NSRC  = (1 << LVL_W) - 1
) (
   input  logic [LVL_W-1:0] code,
   output logic [NSRC-1:0]  sel_oh
);
   logic [LVL_W-1:0] idx;

   generate
      if (NSRC != (1 << LVL_W) - 1) begin : g_bad_nsrc
         $error("NSRC must equal 2**LVL_W - 1");
      end
   endgenerate

   // inverting map: top level lands on index 0, all-zero code on an unused index
   assign idx = code ^ {LVL_W{1'b1}};

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_sel
         assign sel_oh[i] = (idx == LVL_W'(i));
      end
   endgenerate
endmodule

// File: rtl/irl_req_bank.sv
module irl_req_bank
   import irl_level_pkg::*;
#(
   parameter int        NSRC     = 15,
   parameter enf_mode_e ENF_MODE = ENF_STICKY
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd,
   input  logic [NSRC-1:0] sel_oh,
   output logic [NSRC-1:0] req,
   output logic [NSRC-1:0] en_force
);
   generate
      if (NSRC < 1) begin : g_bad_n
         $error("NSRC must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req <= '0;
      end else if (upd) begin
         req <= sel_oh;
      end
   end

   generate
      if (ENF_MODE == ENF_STICKY) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_force <= '0;
            end else if (upd) begin
               en_force <= en_force | sel_oh;
            end
         end
         // R7
         sticky_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_force & ~$past(en_force)) == (en_force ^ $past(en_force)));
      end else begin : g_follow
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_force <= '0;
            end else if (upd) begin
               en_force <= sel_oh;
            end
         end
      end
   endgenerate

   // R8
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req));
   // R6
   req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req & ~en_force) == '0);
   // R4
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(req) && $stable(en_force));
endmodule

// File: rtl/irl_level_decoder.sv
module irl_level_decoder
   import irl_level_pkg::*;
#(
   parameter int        LVL_W    = 4,
   parameter enf_mode_e ENF_MODE = ENF_STICKY,
   localparam int       NSRC     = (1 << LVL_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_valid,
   input  logic [LVL_W-1:0] lvl_code,
   output logic [NSRC-1:0]  src_req,
   output logic [NSRC-1:0]  src_en_force
);
   logic [NSRC-1:0] sel_oh;

   irl_sel_decode #(.LVL_W(LVL_W), .NSRC(NSRC)) u_dec (
      .code   (lvl_code),
      .sel_oh (sel_oh)
   );

   irl_req_bank #(.NSRC(NSRC), .ENF_MODE(ENF_MODE)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (lvl_valid),
      .sel_oh   (sel_oh),
      .req      (src_req),
      .en_force (src_en_force)
   );

   // R3
   zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_valid && (lvl_code == '0) |=> src_req == '0);
   // R2
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_valid && (lvl_code != '0) |=> $countones(src_req) == 1);
endmodule

// File: tb/irl_level_decoder_test.sv
module irl_level_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lvl_valid = 1'b0;
   logic [3:0]  lvl_code = 4'd0;
   logic [14:0] src_req;
   logic [14:0] src_en_force;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [14:0] exp_req = '0;
   logic [14:0] exp_en = '0;
   logic [29:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   irl_level_decoder uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .lvl_valid    (lvl_valid),
      .lvl_code     (lvl_code),
      .src_req      (src_req),
      .src_en_force (src_en_force)
   );

   task automatic step(input logic v, input logic [3:0] c, input string tag);
      @(negedge clk);
      lvl_valid = v;
      lvl_code  = c;
      if (v) begin
         exp_req = '0;
         if (c != 4'd0) exp_req[15 - int'(c)] = 1'b1;
         exp_en = exp_en | exp_req;
      end
      exp_q.push_back({exp_req, exp_en});
      tag_q.push_back(tag);
   endtask

   // monitor: compares just after each edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [29:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         total++;
         if ({src_req, src_en_force} !== e) begin
            bad++;
            $display("FAIL %s req=%h en=%h expected req=%h en=%h",
                     t, src_req, src_en_force, e[29:15], e[14:0]);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      total++;
      if (src_req !== '0 || src_en_force !== '0) begin
         bad++;
         $display("FAIL R1 in reset req=%h en=%h expected 0 0", src_req, src_en_force);
      end
      rst_n = 1'b1;
      step(1'b0, 4'd9, "R1 idle after reset");
      step(1'b0, 4'd3, "R4 code moves without strobe");
      step(1'b1, 4'd15, "R2 level 15 to index 0");
      step(1'b1, 4'd1, "R5 R2 level 1 to index 14");
      step(1'b0, 4'd6, "R4 hold with strobe low");
      step(1'b0, 4'd0, "R4 hold with zero code");
      step(1'b1, 4'd7, "R2 level 7 to index 8");
      step(1'b1, 4'd0, "R3 level 0 clears requests");
      step(1'b0, 4'd12, "R7 force kept while idle");
      for (int l = 1; l < 16; l++) step(1'b1, 4'(l), "R2 R6 R8 level sweep");
      step(1'b1, 4'd0, "R3 R7 level 0 after sweep");
      step(1'b1, 4'd4, "R5 reselect level 4");
      step(1'b1, 4'd4, "R2 same level repeated");
      step(1'b1, 4'd10, "R5 switch to level 10");
      step(1'b0, 4'd0, "R4 final hold");
      repeat (3) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule